// File: doc/BRIEF.md
# Two-Level Interrupt Event Controller

This block gathers interrupt causes from two kinds of source and presents one interrupt line and a source number to a processor. DMA channels raise one-cycle pulses when a descriptor finishes or when a command finishes. Each channel latches those pulses in a small event register of its own, which has a mask beside it. The masked events of a channel are ORed into one summary bit, and that bit sits in a system-level pending register next to the external interrupt pins.

The system level has its own enable mask and a programmable priority for every source. It drives a single interrupt output and the index of the winning source. Software cannot clear a channel's summary bit at the system level. The summary bit drops only once the event bits under it have been cleared by writing ones to the channel's event register, which keeps the two levels consistent.

All state is reached through one register port. Writes take effect on the clock edge that samples them, and reads are combinational from the address.

Top module: `irq_hier_ctrl`

## Requirements
- R1: After reset, every event, mask, pending and priority register reads 0, `irq_o` is 0 and `vec_o` is 0.
- R2: A one-cycle high on `desc_done_i[c]` sets bit 0 of channel c's event register (address 4+2c). A one-cycle high on `cmd_done_i[c]` sets bit 1. A set bit stays set until it is cleared.
- R3: A write to a channel event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: An event pulse that arrives in the same cycle as a write clearing that bit leaves the bit set.
- R5: Pending bit N_EXT+c (address 0) becomes the OR of channel c's event bits ANDed with its mask (address 5+2c, same bit positions). It follows one clock after the event register changes.
- R6: A write to the pending register (address 0) changes nothing.
- R7: A channel's summary pending bit clears only after its unmasked event bits have been cleared through the event register.
- R8: Pending bit i, for i < N_EXT, shows the level of `ext_irq_i[i]` one clock after it is sampled.
- R9: `irq_o` is 1 exactly when some pending bit is also set in the system mask (address 1).
- R10: `vec_o` is the index of the pending, enabled source with the largest priority value. Among equal values the lower index wins.
- R11: The priority of source s is the field at bits [s*PRIO_W +: PRIO_W] of the priority register (address 2). Sources 0..N_EXT-1 are the external pins and N_EXT+c is channel c.
- R12: Channel masks do not stop capture: a masked event is still recorded in the event register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_irq_i | input | N_EXT | External interrupt levels |
| desc_done_i | input | N_CHAN | Per-channel descriptor-completed pulse |
| cmd_done_i | input | N_CHAN | Per-channel command-completed pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for read and write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt request |
| vec_o | output | VEC_W | Index of the winning source |

## Verification
A channel event pulse and a software write-one-to-clear of the same event bit can land on the same clock edge. The bench provokes this by holding the write strobe and the event pulse high across one edge. It then expects the bit to read back as 1, because the new event must win. It also strikes the pending register with all ones while a summary bit is live and checks that only clearing the event register below removes that bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // register addresses
  localparam int ADDR_PEND    = 0;
  localparam int ADDR_SMASK   = 1;
  localparam int ADDR_PRIO    = 2;
  localparam int ADDR_CH_BASE = 4;
  // channel event layout
  localparam int EVT_W    = 2;
  localparam int EVT_DESC = 0;
  localparam int EVT_CMD  = 1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PEND, SEL_SMASK, SEL_PRIO, SEL_CEVT, SEL_CMASK
  } sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n_o = sync_q[1];
endmodule

// File: rtl/irq_chan_evt.sv
module irq_chan_evt #(
  parameter int EW = irq_pkg::EVT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] pulse_i,
  input  logic          clr_wr_i,
  input  logic          mask_wr_i,
  input  logic [EW-1:0] wdata_i,
  output logic [EW-1:0] evt_o,
  output logic [EW-1:0] mask_o,
  output logic          summ_o
);
  logic [EW-1:0] evt_q, evt_d;
  logic [EW-1:0] mask_q, mask_d;
  logic [EW-1:0] clr;

  always_comb begin
    clr    = clr_wr_i ? wdata_i : '0;
    // new event takes precedence over a simultaneous clear
    evt_d  = (evt_q & ~clr) | pulse_i;
    mask_d = mask_wr_i ? wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q  <= evt_d;
      if (mask_wr_i) mask_q <= mask_d;
    end
  end

  assign evt_o  = evt_q;
  assign mask_o = mask_q;
  assign summ_o = |(evt_q & mask_q);

  // R2: a set bit not being cleared stays set
  p_evt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(evt_q) & ~$past(clr)) & ~evt_q) == '0));

  // R4: an incoming pulse always lands, clear or not
  p_evt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i != '0) |=> ((evt_q & $past(pulse_i)) == $past(pulse_i)));

  // R3: a bit with no pulse and a clear is gone next cycle
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && (wdata_i & ~pulse_i) != '0) |=> ((evt_q & $past(wdata_i & ~pulse_i)) == '0));
endmodule

// File: rtl/irq_sys_level.sv
module irq_sys_level #(
  parameter int N_EXT  = 4,
  parameter int N_CHAN = 2,
  parameter int PRIO_W = 2,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_EXT-1:0]               ext_i,
  input  logic [N_CHAN-1:0]              summ_i,
  input  logic                           smask_wr_i,
  input  logic                           prio_wr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [N_EXT+N_CHAN-1:0]        pend_o,
  output logic [N_EXT+N_CHAN-1:0]        smask_o,
  output logic [(N_EXT+N_CHAN)*PRIO_W-1:0] prio_o
);
  localparam int N_SRC = N_EXT + N_CHAN;
  localparam int PR_W  = N_SRC * PRIO_W;

  logic [N_SRC-1:0] pend_q, pend_d;
  logic [N_SRC-1:0] smask_q, smask_d;
  logic [PR_W-1:0]  prio_q, prio_d;

  always_comb begin
    // pending has no write path: it only mirrors its sources
    pend_d  = {summ_i, ext_i};
    smask_d = smask_wr_i ? wdata_i[N_SRC-1:0] : smask_q;
    prio_d  = prio_wr_i  ? wdata_i[PR_W-1:0]  : prio_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      smask_q <= '0;
      prio_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (smask_wr_i) smask_q <= smask_d;
      if (prio_wr_i)  prio_q  <= prio_d;
    end
  end

  assign pend_o  = pend_q;
  assign smask_o = smask_q;
  assign prio_o  = prio_q;

  // R8: external pending bits track the pins with one clock of delay
  p_ext_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q[N_EXT-1:0] == $past(ext_i)));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N_SRC  = 6,
  parameter int PRIO_W = 2,
  parameter int VEC_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    irq_o,
  output logic [VEC_W-1:0]        vec_o
);
  logic              found;
  logic [PRIO_W-1:0] best_p;
  logic [VEC_W-1:0]  best_i;

  always_comb begin
    found  = 1'b0;
    best_p = '0;
    best_i = '0;
    // strict compare: an equal priority never displaces a lower index
    for (int s = 0; s < N_SRC; s++) begin
      if (req_i[s] && (!found || prio_i[s*PRIO_W +: PRIO_W] > best_p)) begin
        found  = 1'b1;
        best_p = prio_i[s*PRIO_W +: PRIO_W];
        best_i = VEC_W'(s);
      end
    end
  end

  assign irq_o = found;
  assign vec_o = best_i;
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl #(
  parameter int N_EXT  = 4,
  parameter int N_CHAN = 2,
  parameter int PRIO_W = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int VEC_W  = $clog2(N_EXT + N_CHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_irq_i,
  input  logic [N_CHAN-1:0] desc_done_i,
  input  logic [N_CHAN-1:0] cmd_done_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  import irq_pkg::*;

  localparam int N_SRC = N_EXT + N_CHAN;
  localparam int PR_W  = N_SRC * PRIO_W;

  logic srst_n;
  logic [N_CHAN-1:0]       chan_summ;
  logic [N_CHAN-1:0]       chan_clr_wr, chan_mask_wr;
  logic [EVT_W-1:0]        chan_evt  [N_CHAN];
  logic [EVT_W-1:0]        chan_mask [N_CHAN];
  logic [N_SRC-1:0]        pend, smask, active;
  logic [PR_W-1:0]         prio;
  sel_e                    sel;
  int                      sel_ch;

  irq_rst_sync u_rst (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (srst_n)
  );

  // address decode
  always_comb begin
    sel    = SEL_NONE;
    sel_ch = 0;
    if (addr_i == ADDR_W'(ADDR_PEND))  sel = SEL_PEND;
    if (addr_i == ADDR_W'(ADDR_SMASK)) sel = SEL_SMASK;
    if (addr_i == ADDR_W'(ADDR_PRIO))  sel = SEL_PRIO;
    for (int c = 0; c < N_CHAN; c++) begin
      if (addr_i == ADDR_W'(ADDR_CH_BASE + 2*c)) begin
        sel    = SEL_CEVT;
        sel_ch = c;
      end
      if (addr_i == ADDR_W'(ADDR_CH_BASE + 2*c + 1)) begin
        sel    = SEL_CMASK;
        sel_ch = c;
      end
    end
  end

  generate
    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      assign chan_clr_wr[c]  = wr_en_i && sel == SEL_CEVT  && sel_ch == c;
      assign chan_mask_wr[c] = wr_en_i && sel == SEL_CMASK && sel_ch == c;

      logic [EVT_W-1:0] pulse;
      always_comb begin
        pulse           = '0;
        pulse[EVT_DESC] = desc_done_i[c];
        pulse[EVT_CMD]  = cmd_done_i[c];
      end

      irq_chan_evt #(.EW(EVT_W)) u_chan (
        .clk       (clk),
        .rst_n     (srst_n),
        .pulse_i   (pulse),
        .clr_wr_i  (chan_clr_wr[c]),
        .mask_wr_i (chan_mask_wr[c]),
        .wdata_i   (wdata_i[EVT_W-1:0]),
        .evt_o     (chan_evt[c]),
        .mask_o    (chan_mask[c]),
        .summ_o    (chan_summ[c])
      );

      // R7: summary pending is only ever backed by a live masked event
      p_summ_backed_r7: assert property (@(posedge clk) disable iff (!srst_n)
        pend[N_EXT+c] |-> $past(chan_summ[c]));
    end
  endgenerate

  irq_sys_level #(
    .N_EXT(N_EXT), .N_CHAN(N_CHAN), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
  ) u_sys (
    .clk        (clk),
    .rst_n      (srst_n),
    .ext_i      (ext_irq_i),
    .summ_i     (chan_summ),
    .smask_wr_i (wr_en_i && sel == SEL_SMASK),
    .prio_wr_i  (wr_en_i && sel == SEL_PRIO),
    .wdata_i    (wdata_i),
    .pend_o     (pend),
    .smask_o    (smask),
    .prio_o     (prio)
  );

  assign active = pend & smask;

  irq_prio_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_arb (
    .req_i  (active),
    .prio_i (prio),
    .irq_o  (irq_o),
    .vec_o  (vec_o)
  );

  // read mux
  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_PEND:  rdata_o = DATA_W'(pend);
      SEL_SMASK: rdata_o = DATA_W'(smask);
      SEL_PRIO:  rdata_o = DATA_W'(prio);
      SEL_CEVT:  rdata_o = DATA_W'(chan_evt[sel_ch]);
      SEL_CMASK: rdata_o = DATA_W'(chan_mask[sel_ch]);
      default:   rdata_o = '0;
    endcase
  end

  // R9: the request line implies an enabled pending source
  p_irq_needs_src_r9: assert property (@(posedge clk) disable iff (!srst_n)
    irq_o |-> (active != '0));

  // R10: the reported vector is itself an enabled pending source
  p_vec_active_r10: assert property (@(posedge clk) disable iff (!srst_n)
    irq_o |-> active[vec_o]);
endmodule

// File: tb/irq_hier_ctrl_tb.sv
module irq_hier_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int N_EXT  = 4;
  localparam int N_CHAN = 2;
  localparam int DW     = 32;
  localparam int AW     = 8;
  localparam int VW     = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N_EXT-1:0]  ext_irq;
  logic [N_CHAN-1:0] desc_done, cmd_done;
  logic              wr_en;
  logic [AW-1:0]     addr;
  logic [DW-1:0]     wdata;
  logic [DW-1:0]     rdata;
  logic              irq;
  logic [VW-1:0]     vec;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_hier_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq),
    .desc_done_i(desc_done), .cmd_done_i(cmd_done),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .vec_o(vec)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    addr = AW'(a);
    #1 check(req, rdata, exp);
  endtask

  task automatic pulse(input logic [N_CHAN-1:0] d, input logic [N_CHAN-1:0] c);
    @(negedge clk);
    desc_done = d; cmd_done = c;
    @(negedge clk);
    desc_done = '0; cmd_done = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(0, 0, "R1 pend");
    rd(1, 0, "R1 smask");
    rd(2, 0, "R1 prio");
    rd(4, 0, "R1 ch0 evt");
    rd(7, 0, "R1 ch1 mask");
    check("R1 irq", DW'(irq), 0);
    check("R1 vec", DW'(vec), 0);
  endtask

  task automatic t_capture;
    pulse(2'b01, 2'b00);
    rd(4, 1, "R2 R12 desc captured while masked");
    pulse(2'b00, 2'b10);
    rd(6, 2, "R2 cmd on ch1 bit1");
    idle(3);
    rd(4, 1, "R2 ch0 sticky");
    rd(6, 2, "R2 ch1 sticky");
  endtask

  task automatic t_w1c;
    wr(4, 0);
    rd(4, 1, "R3 write 0 keeps");
    wr(4, 1);
    rd(4, 0, "R3 write 1 clears");
    wr(6, 1);
    rd(6, 2, "R3 other bit kept");
    wr(6, 2);
    rd(6, 0, "R3 ch1 cleared");
  endtask

  task automatic t_collide;
    pulse(2'b01, 2'b00);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(4); wdata = 1; desc_done = 2'b01;
    @(negedge clk);
    wr_en = 1'b0; desc_done = '0;
    rd(4, 1, "R4 event beats clear");
    wr(4, 1);
    rd(4, 0, "R4 later clear works");
  endtask

  task automatic t_summary;
    wr(5, 1);
    pulse(2'b00, 2'b01);
    idle(2);
    rd(0, 0, "R5 masked event no summary");
    pulse(2'b01, 2'b00);
    idle(2);
    rd(0, 32'h10, "R5 summary set");
    wr(0, 32'hFFFF_FFFF);
    idle(2);
    rd(0, 32'h10, "R6 pending write ignored");
    wr(4, 2);
    idle(2);
    rd(0, 32'h10, "R7 clearing masked bit keeps summary");
    wr(4, 1);
    idle(2);
    rd(0, 0, "R7 summary cleared via event reg");
    wr(5, 0);
  endtask

  task automatic t_ext;
    @(negedge clk);
    ext_irq = 4'b0101;
    rd(0, 32'h5, "R8 ext levels");
    ext_irq = 4'b0000;
    rd(0, 0, "R8 ext dropped");
  endtask

  task automatic t_mask_irq;
    @(negedge clk);
    ext_irq = 4'b0001;
    idle(2);
    check("R9 disabled no irq", DW'(irq), 0);
    wr(1, 1);
    #1 check("R9 enabled irq", DW'(irq), 1);
    check("R10 vec 0", DW'(vec), 0);
    wr(1, 0);
    #1 check("R9 disabled again", DW'(irq), 0);
    ext_irq = '0;
  endtask

  task automatic t_prio;
    @(negedge clk);
    ext_irq = 4'b1111;
    wr(1, 32'h0F);
    idle(2);
    check("R10 tie lowest index", DW'(vec), 0);
    wr(2, 32'h30);
    #1 check("R11 src2 highest", DW'(vec), 2);
    wr(2, 32'h3C);
    #1 check("R10 tie src1 over src2", DW'(vec), 1);
    rd(2, 32'h3C, "R11 prio readback");
    wr(7, 1);
    pulse(2'b10, 2'b00);
    wr(1, 32'h3F);
    wr(2, 32'hC00);
    idle(2);
    check("R11 ch1 summary src5 wins", DW'(vec), 5);
    check("R9 irq on", DW'(irq), 1);
    wr(1, 32'h1F);
    #1 check("R10 src5 disabled back to 0", DW'(vec), 0);
    ext_irq = '0;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_irq = '0; desc_done = '0; cmd_done = '0;
    wr_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_capture;
    t_w1c;
    t_collide;
    t_summary;
    t_ext;
    t_mask_irq;
    t_prio;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule